// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Branch Condition Check

This block is the execute stage of a small RISC core. In one cycle it combines a source operand, a destination operand and a 5-bit immediate field under a 5-bit operation select. It returns the value to write back, a write enable, and the next zero, negative and carry flags. The flags sit in a three-bit register inside the block. They change on the clock edge where an operation is presented, so carry-in for the chained add and subtract forms always comes from the previous flag-setting operation.

A combinational branch checker sits beside the ALU. It reads the registered flags and a 5-bit condition code and says whether a conditional jump is taken. Two bits of the code test Z, two test a second flag, and one bit picks C or N as that second flag. The arithmetic covers add and subtract with and without carry, the quick-immediate forms where a zero field means a full word, and compare. It also covers absolute value, negate, logic and single-bit operations, rotates, shifts whose count is signed, and unsigned clamps to 8, 16 and 24 bits.

Top module: `alu_flags_unit`

## Requirements
- R1: Synchronous active-high reset clears Z, N and C to 0. The flags change only on a rising clock edge with `op_valid` high. While `op_valid` is low, `wr_en` is 0 and the flags hold. Z is 1 exactly when the written result is 0. N equals bit 31 of the written result for every operation that updates N, except absolute value.
- R2: `op_sel` encodings are: 0 ADD, 1 ADDC, 2 ADDQ, 3 ADDQT, 4 SUB, 5 SUBC, 6 SUBQ, 7 SUBQT, 8 CMP, 9 CMPQ, 10 ABS, 11 NEG, 12 AND, 13 OR, 14 XOR, 15 NOT, 16 BSET, 17 BCLR, 18 BTST, 19 ROR, 20 RORQ, 21 SH, 22 SHA, 23 SHRQ, 24 SHARQ, 25 SAT8, 26 SAT16, 27 SAT24. CMP, CMPQ and BTST never write. Codes 28 to 31 neither write nor change a flag.
- R3: ADD gives dst+src, and ADDC gives dst+src+C, with C set to the carry out. SUB gives dst-src, and SUBC gives dst-src-C, with C set to the borrow. All four update Z, N and C.
- R4: ADDQ and SUBQ add or subtract the immediate, reading an immediate of 0 as 32. They update Z, N and C as in R3.
- R5: ADDQT and SUBQT compute the same sums as ADDQ and SUBQ (0 reads as 32) and leave all three flags unchanged.
- R6: CMP sets Z, N and C from dst-src. CMPQ sets them from dst minus the sign-extended 5-bit immediate. C reports the borrow.
- R7: ABS writes -dst when dst bit 31 is 1, and dst otherwise. C is set to dst bit 31, N is cleared, and Z follows the result. NEG writes 0-dst and sets Z, N, and C as the borrow (C=1 for any nonzero dst).
- R8: AND, OR and XOR combine dst with src, and NOT inverts dst. All four update Z and N and leave C unchanged.
- R9: BSET and BCLR set or clear dst bit `imm`, write the result, update Z and N, and keep C. BTST sets Z to the inverse of dst bit `imm` and leaves N and C unchanged.
- R10: ROR rotates dst right by src[4:0]. RORQ rotates dst right by the immediate, where 0 reads as 32 and leaves dst as it is. Both set C to the old dst bit 31 and update Z and N.
- R11: SH and SHA treat src as a signed count. A negative count shifts dst left by its magnitude and sets C to the old bit 31. A count of zero or more shifts right and sets C to the old bit 0. SH shifts right logically and SHA arithmetically. A magnitude of 32 or more gives 0, except that an arithmetic right shift gives 32 copies of dst bit 31.
- R12: SHRQ shifts right logically and SHARQ arithmetically by the immediate, where 0 reads as 32. A full 32 gives 0 for SHRQ and a sign fill for SHARQ. Both set C to the old bit 0 and update Z and N.
- R13: SAT8, SAT16 and SAT24 treat dst as signed. A negative value gives 0, and a value above 255, 65535 or 16777215 gives that limit. The clamps update Z and N and keep C.
- R14: `branch_taken` is 1 unless an enabled test fails. The tests are: code bit 0 requires Z=0, bit 1 requires Z=1, bit 2 requires the tested flag to be 0, and bit 3 requires it to be 1. The tested flag is C when bit 4 is 0 and N when bit 4 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_valid | input | 1 | An operation is presented this cycle |
| op_sel | input | 5 | Operation select, encoded as in R2 |
| src_a | input | 32 | Source register operand (second operand, count or mask source) |
| src_b | input | 32 | Destination register operand (first operand, value operated on) |
| imm | input | 5 | Immediate field: quick constant, bit index or signed compare value |
| cond_code | input | 5 | Branch condition code |
| result | output | 32 | Value to write to the destination register |
| wr_en | output | 1 | Result is to be written this cycle |
| flag_z | output | 1 | Registered zero flag |
| flag_n | output | 1 | Registered negative flag |
| flag_c | output | 1 | Registered carry/borrow flag |
| branch_taken | output | 1 | Condition code passes against the registered flags |

## Verification
The bench builds the block with its default 32-bit data path and 5-bit immediate. In that configuration every value of the immediate can be swept, including the zero that stands for a full word. The same holds for every operation code, the unused ones included. The operand sets sit on the edges that matter: signed shift counts of ±31, ±32 and ±33, the clamp limits and one past each, and the most negative word for absolute value and negate. All 32 condition codes are run against all 8 flag states, which are set up through ordinary operations.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [4:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_ADDQ  = 5'd2,
        OP_ADDQT = 5'd3,
        OP_SUB   = 5'd4,
        OP_SUBC  = 5'd5,
        OP_SUBQ  = 5'd6,
        OP_SUBQT = 5'd7,
        OP_CMP   = 5'd8,
        OP_CMPQ  = 5'd9,
        OP_ABS   = 5'd10,
        OP_NEG   = 5'd11,
        OP_AND   = 5'd12,
        OP_OR    = 5'd13,
        OP_XOR   = 5'd14,
        OP_NOT   = 5'd15,
        OP_BSET  = 5'd16,
        OP_BCLR  = 5'd17,
        OP_BTST  = 5'd18,
        OP_ROR   = 5'd19,
        OP_RORQ  = 5'd20,
        OP_SH    = 5'd21,
        OP_SHA   = 5'd22,
        OP_SHRQ  = 5'd23,
        OP_SHARQ = 5'd24,
        OP_SAT8  = 5'd25,
        OP_SAT16 = 5'd26,
        OP_SAT24 = 5'd27
    } alu_op_e;

    typedef enum logic [1:0] {
        UNIT_ARITH,
        UNIT_LOGIC,
        UNIT_SHIFT,
        UNIT_NONE
    } alu_unit_e;

    // How an operation moves the flag register
    typedef enum logic [2:0] {
        FLG_KEEP,      // no flag changes
        FLG_ZN,        // Z and N from result, C kept
        FLG_ZNC,       // Z and N from result, C from unit
        FLG_ZC_NCLR,   // Z from result, N cleared, C from unit
        FLG_ZBIT       // Z from tested bit only
    } flag_policy_e;

    typedef struct packed {
        logic z;
        logic n;
        logic c;
    } alu_flags_t;

    typedef struct packed {
        logic         writes;
        alu_unit_e    unit;
        flag_policy_e policy;
    } op_info_t;

    function automatic op_info_t make_info(input logic w, input alu_unit_e u,
                                           input flag_policy_e p);
        op_info_t i;
        i.writes = w;
        i.unit   = u;
        i.policy = p;
        return i;
    endfunction

    function automatic op_info_t decode_op(input logic [4:0] code);
        op_info_t info;
        case (code)
            OP_ADD, OP_ADDC, OP_ADDQ,
            OP_SUB, OP_SUBC, OP_SUBQ,
            OP_NEG:              info = make_info(1'b1, UNIT_ARITH, FLG_ZNC);
            OP_ADDQT, OP_SUBQT:  info = make_info(1'b1, UNIT_ARITH, FLG_KEEP);
            OP_CMP, OP_CMPQ:     info = make_info(1'b0, UNIT_ARITH, FLG_ZNC);
            OP_ABS:              info = make_info(1'b1, UNIT_ARITH, FLG_ZC_NCLR);
            OP_AND, OP_OR, OP_XOR, OP_NOT,
            OP_BSET, OP_BCLR,
            OP_SAT8, OP_SAT16,
            OP_SAT24:            info = make_info(1'b1, UNIT_LOGIC, FLG_ZN);
            OP_BTST:             info = make_info(1'b0, UNIT_LOGIC, FLG_ZBIT);
            OP_ROR, OP_RORQ, OP_SH, OP_SHA,
            OP_SHRQ, OP_SHARQ:   info = make_info(1'b1, UNIT_SHIFT, FLG_ZNC);
            default:             info = make_info(1'b0, UNIT_NONE, FLG_KEEP);
        endcase
        return info;
    endfunction

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    input  logic              c_in,
    output logic [DATA_W-1:0] sum_out,
    output logic              carry_out
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] quick_val;
    logic [DATA_W-1:0] sext_val;
    logic [DATA_W-1:0] lhs;
    logic [DATA_W-1:0] rhs;
    logic              subtract;
    logic              use_cin;
    logic              cin;
    logic [DATA_W:0]   wide;

    always_comb begin
        quick_val = (imm == '0) ? DATA_W'(DATA_W) : DATA_W'(imm);
        sext_val  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
        lhs       = opb;
        rhs       = opa;
        subtract  = 1'b0;
        use_cin   = 1'b0;
        case (op_code)
            OP_ADDC:            use_cin = 1'b1;
            OP_ADDQ, OP_ADDQT:  rhs = quick_val;
            OP_SUB, OP_CMP:     subtract = 1'b1;
            OP_SUBC: begin
                subtract = 1'b1;
                use_cin  = 1'b1;
            end
            OP_SUBQ, OP_SUBQT: begin
                subtract = 1'b1;
                rhs      = quick_val;
            end
            OP_CMPQ: begin
                subtract = 1'b1;
                rhs      = sext_val;
            end
            OP_NEG: begin
                subtract = 1'b1;
                lhs      = '0;
                rhs      = opb;
            end
            OP_ABS: begin
                if (opb[MSB]) begin
                    subtract = 1'b1;
                    lhs      = '0;
                    rhs      = opb;
                end else begin
                    rhs = '0;
                end
            end
            default: ;
        endcase
        cin = use_cin & c_in;
        if (subtract)
            wide = {1'b0, lhs} - {1'b0, rhs} - (DATA_W+1)'(cin);
        else
            wide = {1'b0, lhs} + {1'b0, rhs} + (DATA_W+1)'(cin);
        sum_out   = wide[DATA_W-1:0];
        carry_out = wide[DATA_W];
    end

endmodule

// File: rtl/alu_logic.sv
module alu_logic
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] logic_out,
    output logic              bit_zero
);
    localparam int MSB      = DATA_W - 1;
    localparam int NUM_SAT  = 3;
    localparam int SAT_BITS [NUM_SAT] = '{8, 16, 24};

    logic [DATA_W-1:0] bit_mask;
    logic [DATA_W-1:0] sat_res [NUM_SAT];

    assign bit_mask = DATA_W'(1) << imm;
    assign bit_zero = ~opb[imm];

    for (genvar g = 0; g < NUM_SAT; g++) begin : g_sat
        localparam logic [DATA_W-1:0] LIMIT = DATA_W'((64'd1 << SAT_BITS[g]) - 64'd1);
        assign sat_res[g] = opb[MSB]      ? '0    :
                            (opb > LIMIT) ? LIMIT : opb;
    end

    always_comb begin
        case (op_code)
            OP_AND:   logic_out = opb & opa;
            OP_OR:    logic_out = opb | opa;
            OP_XOR:   logic_out = opb ^ opa;
            OP_NOT:   logic_out = ~opb;
            OP_BSET:  logic_out = opb | bit_mask;
            OP_BCLR:  logic_out = opb & ~bit_mask;
            OP_SAT8:  logic_out = sat_res[0];
            OP_SAT16: logic_out = sat_res[1];
            OP_SAT24: logic_out = sat_res[2];
            default:  logic_out = '0;
        endcase
    end

endmodule

// File: rtl/alu_shifter.sv
module alu_shifter
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic [4:0]        op_code,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] shift_out,
    output logic              carry_out
);
    localparam int MSB  = DATA_W - 1;
    localparam int SH_W = $clog2(DATA_W);

    logic                neg_cnt;
    logic [DATA_W-1:0]   mag;
    logic [SH_W:0]       quick_cnt;
    logic                big;
    logic [SH_W-1:0]     amt;
    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W-1:0]   left_v;
    logic [DATA_W-1:0]   right_v;
    logic [DATA_W-1:0]   arith_v;
    logic [DATA_W-1:0]   rot_v;

    always_comb begin
        neg_cnt   = opa[MSB];
        mag       = neg_cnt ? (~opa + DATA_W'(1)) : opa;
        quick_cnt = (imm == '0) ? (SH_W+1)'(DATA_W) : (SH_W+1)'(imm);
        case (op_code)
            OP_SH, OP_SHA: begin
                big = |mag[DATA_W-1:SH_W];
                amt = mag[SH_W-1:0];
            end
            OP_ROR: begin
                big = 1'b0;
                amt = opa[SH_W-1:0];
            end
            default: begin
                big = quick_cnt[SH_W];
                amt = quick_cnt[SH_W-1:0];
            end
        endcase

        left_v  = big ? '0 : (opb << amt);
        right_v = big ? '0 : (opb >> amt);
        arith_v = big ? {DATA_W{opb[MSB]}} : DATA_W'($signed(opb) >>> amt);
        dbl     = {opb, opb} >> amt;
        rot_v   = dbl[DATA_W-1:0];

        case (op_code)
            OP_ROR, OP_RORQ: begin
                shift_out = rot_v;
                carry_out = opb[MSB];
            end
            OP_SH: begin
                shift_out = neg_cnt ? left_v : right_v;
                carry_out = neg_cnt ? opb[MSB] : opb[0];
            end
            OP_SHA: begin
                shift_out = neg_cnt ? left_v : arith_v;
                carry_out = neg_cnt ? opb[MSB] : opb[0];
            end
            OP_SHRQ: begin
                shift_out = right_v;
                carry_out = opb[0];
            end
            OP_SHARQ: begin
                shift_out = arith_v;
                carry_out = opb[0];
            end
            default: begin
                shift_out = '0;
                carry_out = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/alu_branch_check.sv
module alu_branch_check
    import alu_flags_pkg::*;
(
    input  logic [4:0]  cond,
    input  alu_flags_t  flags,
    output logic        taken
);
    logic second_flag;
    logic fail_z_set;
    logic fail_z_clear;
    logic fail_t_set;
    logic fail_t_clear;

    always_comb begin
        second_flag  = cond[4] ? flags.n : flags.c;
        fail_z_set   = cond[0] &  flags.z;
        fail_z_clear = cond[1] & ~flags.z;
        fail_t_set   = cond[2] &  second_flag;
        fail_t_clear = cond[3] & ~second_flag;
        taken = ~(fail_z_set | fail_z_clear | fail_t_set | fail_t_clear);
    end

endmodule

// File: rtl/alu_flags_unit.sv
module alu_flags_unit
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [4:0]        op_sel,
    input  logic [DATA_W-1:0] src_a,
    input  logic [DATA_W-1:0] src_b,
    input  logic [IMM_W-1:0]  imm,
    input  logic [4:0]        cond_code,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              flag_z,
    output logic              flag_n,
    output logic              flag_c,
    output logic              branch_taken
);
    localparam int MSB = DATA_W - 1;

    op_info_t          info;
    alu_flags_t        flags_q;
    alu_flags_t        flags_d;
    logic [DATA_W-1:0] arith_res;
    logic              arith_c;
    logic [DATA_W-1:0] logic_res;
    logic              bit_zero;
    logic [DATA_W-1:0] shift_res;
    logic              shift_c;
    logic [DATA_W-1:0] sel_res;
    logic              sel_c;
    logic              res_zero;

    assign info = decode_op(op_sel);

    alu_addsub #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_addsub (
        .op_code   (op_sel),
        .opa       (src_a),
        .opb       (src_b),
        .imm       (imm),
        .c_in      (flags_q.c),
        .sum_out   (arith_res),
        .carry_out (arith_c)
    );

    alu_logic #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_logic (
        .op_code   (op_sel),
        .opa       (src_a),
        .opb       (src_b),
        .imm       (imm),
        .logic_out (logic_res),
        .bit_zero  (bit_zero)
    );

    alu_shifter #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_shifter (
        .op_code   (op_sel),
        .opa       (src_a),
        .opb       (src_b),
        .imm       (imm),
        .shift_out (shift_res),
        .carry_out (shift_c)
    );

    alu_branch_check u_branch (
        .cond  (cond_code),
        .flags (flags_q),
        .taken (branch_taken)
    );

    always_comb begin
        case (info.unit)
            UNIT_ARITH: begin
                sel_res = arith_res;
                sel_c   = arith_c;
            end
            UNIT_LOGIC: begin
                sel_res = logic_res;
                sel_c   = flags_q.c;
            end
            UNIT_SHIFT: begin
                sel_res = shift_res;
                sel_c   = shift_c;
            end
            default: begin
                sel_res = '0;
                sel_c   = flags_q.c;
            end
        endcase
        res_zero = (sel_res == '0);

        flags_d = flags_q;
        case (info.policy)
            FLG_ZN: begin
                flags_d.z = res_zero;
                flags_d.n = sel_res[MSB];
            end
            FLG_ZNC: begin
                flags_d.z = res_zero;
                flags_d.n = sel_res[MSB];
                flags_d.c = sel_c;
            end
            FLG_ZC_NCLR: begin
                flags_d.z = res_zero;
                flags_d.n = 1'b0;
                flags_d.c = sel_c;
            end
            FLG_ZBIT: flags_d.z = bit_zero;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            flags_q <= '0;
        else if (op_valid)
            flags_q <= flags_d;
    end

    assign result = sel_res;
    assign wr_en  = op_valid & info.writes;
    assign flag_z = flags_q.z;
    assign flag_n = flags_q.n;
    assign flag_c = flags_q.c;

endmodule

// File: rtl/alu_flags_unit_sva.sv
module alu_flags_unit_sva
    import alu_flags_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 5
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [4:0]        op_sel,
    input logic [DATA_W-1:0] src_a,
    input logic [DATA_W-1:0] src_b,
    input logic [IMM_W-1:0]  imm,
    input logic [4:0]        cond_code,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              flag_z,
    input logic              flag_n,
    input logic              flag_c,
    input logic              branch_taken
);
    localparam int MSB = DATA_W - 1;

    AST_IDLE_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> $stable({flag_z, flag_n, flag_c})); // R1

    AST_ADD_N_TRACKS_RESULT: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_ADD) |=> (flag_n == $past(result[MSB]))); // R3

    AST_NO_WRITE_COMPARE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_CMP || op_sel == OP_CMPQ || op_sel == OP_BTST)) |-> !wr_en); // R2

    AST_QUICKT_FLAGS_HOLD: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_ADDQT || op_sel == OP_SUBQT))
        |=> $stable({flag_z, flag_n, flag_c})); // R5

    AST_ABS_CLEARS_N: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_ABS) |=> !flag_n); // R7

    AST_LOGIC_KEEPS_C: assert property (@(posedge clk) disable iff (rst)
        (op_valid && (op_sel == OP_AND || op_sel == OP_OR || op_sel == OP_XOR || op_sel == OP_NOT))
        |=> $stable(flag_c)); // R8

    AST_BTST_KEEPS_NC: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_BTST) |=> $stable({flag_n, flag_c})); // R9

    AST_SAT8_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_sel == OP_SAT8) |-> (result <= DATA_W'(255))); // R13

    AST_BRANCH_Z_MASK: assert property (@(posedge clk) disable iff (rst)
        (cond_code[0] && flag_z) |-> !branch_taken); // R14

    AST_BRANCH_NO_TEST: assert property (@(posedge clk) disable iff (rst)
        (cond_code[3:0] == 4'd0) |-> branch_taken); // R14

endmodule

bind alu_flags_unit alu_flags_unit_sva #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sva (.*);

// File: tb/alu_flags_unit_bench.sv
`timescale 1ns/1ps
module alu_flags_unit_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [4:0]  op_sel = '0;
    logic [31:0] src_a = '0;
    logic [31:0] src_b = '0;
    logic [4:0]  imm = '0;
    logic [4:0]  cond_code = '0;
    logic [31:0] result;
    logic        wr_en;
    logic        flag_z;
    logic        flag_n;
    logic        flag_c;
    logic        branch_taken;

    int checks = 0;
    int errors = 0;
    logic mz = 1'b0;
    logic mn = 1'b0;
    logic mc = 1'b0;

    always #5 clk = ~clk;

    alu_flags_unit u_alu_flags_unit (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
        .src_a(src_a), .src_b(src_b), .imm(imm), .cond_code(cond_code),
        .result(result), .wr_en(wr_en), .flag_z(flag_z), .flag_n(flag_n),
        .flag_c(flag_c), .branch_taken(branch_taken)
    );

    function automatic logic [31:0] val_a(input int i);
        case (i)
            0: return 32'h0000_0000;   1: return 32'h0000_0001;
            2: return 32'h0000_0005;   3: return 32'h0000_001F;
            4: return 32'h0000_0020;   5: return 32'h0000_0021;
            6: return 32'hFFFF_FFFF;   7: return 32'hFFFF_FFFB;
            8: return 32'hFFFF_FFE1;   9: return 32'hFFFF_FFE0;
            10: return 32'hFFFF_FFDF;  11: return 32'h8000_0000;
            12: return 32'h7FFF_FFFF;  13: return 32'h0000_0100;
            14: return 32'h00FF_FFFF;  default: return 32'h1234_ABCD;
        endcase
    endfunction

    function automatic logic [31:0] val_b(input int i);
        case (i)
            0: return 32'h0000_0000;   1: return 32'h0000_0001;
            2: return 32'h8000_0000;   3: return 32'hFFFF_FFFF;
            4: return 32'h7FFF_FFFF;   5: return 32'h0000_00FF;
            6: return 32'h0000_0100;   7: return 32'h0000_FFFF;
            8: return 32'h0001_0000;   9: return 32'h00FF_FFFF;
            10: return 32'h0100_0000;  default: return 32'hA5C3_E187;
        endcase
    endfunction

    function automatic logic [4:0] val_imm(input int i);
        case (i)
            0: return 5'd0;  1: return 5'd1;  2: return 5'd5;
            3: return 5'd15; 4: return 5'd16; default: return 5'd31;
        endcase
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 1, 4, 5:       return "R3";
            2, 6:             return "R4";
            3, 7:             return "R5";
            8, 9:             return "R6";
            10, 11:           return "R7";
            12, 13, 14, 15:   return "R8";
            16, 17, 18:       return "R9";
            19, 20:           return "R10";
            21, 22:           return "R11";
            23, 24:           return "R12";
            25, 26, 27:       return "R13";
            default:          return "R2";
        endcase
    endfunction

    // Expected behaviour from the requirements
    function automatic void ref_op(input int op, input logic [31:0] a, input logic [31:0] b,
                                   input logic [4:0] im, input logic fz, input logic fn,
                                   input logic fc, output logic [31:0] r, output logic w,
                                   output logic z, output logic n, output logic c);
        logic [32:0]        t;
        logic [31:0]        q;
        logic [31:0]        sx;
        logic signed [31:0] bs;
        longint             sa;
        longint             lim;
        int                 zn_mode;   // 0 keep, 1 Z and N from r
        q  = (im == 5'd0) ? 32'd32 : {27'd0, im};
        sx = {{27{im[4]}}, im};
        bs = b;
        sa = longint'($signed(a));
        r = '0; w = 1'b0; z = fz; n = fn; c = fc; zn_mode = 0;
        case (op)
            0:  begin t = {1'b0, b} + {1'b0, a};              r = t[31:0]; c = t[32]; w = 1; zn_mode = 1; end
            1:  begin t = {1'b0, b} + {1'b0, a} + 33'(fc);    r = t[31:0]; c = t[32]; w = 1; zn_mode = 1; end
            2:  begin t = {1'b0, b} + {1'b0, q};              r = t[31:0]; c = t[32]; w = 1; zn_mode = 1; end
            3:  begin r = b + q; w = 1; end
            4:  begin t = {1'b0, b} - {1'b0, a};              r = t[31:0]; c = t[32]; w = 1; zn_mode = 1; end
            5:  begin t = {1'b0, b} - {1'b0, a} - 33'(fc);    r = t[31:0]; c = t[32]; w = 1; zn_mode = 1; end
            6:  begin t = {1'b0, b} - {1'b0, q};              r = t[31:0]; c = t[32]; w = 1; zn_mode = 1; end
            7:  begin r = b - q; w = 1; end
            8:  begin t = {1'b0, b} - {1'b0, a};  r = t[31:0]; c = t[32]; zn_mode = 1; end
            9:  begin t = {1'b0, b} - {1'b0, sx}; r = t[31:0]; c = t[32]; zn_mode = 1; end
            10: begin
                r = b[31] ? (32'd0 - b) : b;
                c = b[31]; n = 1'b0; z = (r == 0); w = 1;
            end
            11: begin r = 32'd0 - b; c = (b != 0); w = 1; zn_mode = 1; end
            12: begin r = b & a; w = 1; zn_mode = 1; end
            13: begin r = b | a; w = 1; zn_mode = 1; end
            14: begin r = b ^ a; w = 1; zn_mode = 1; end
            15: begin r = ~b;    w = 1; zn_mode = 1; end
            16: begin r = b | (32'd1 << im);  w = 1; zn_mode = 1; end
            17: begin r = b & ~(32'd1 << im); w = 1; zn_mode = 1; end
            18: begin z = ~b[im]; end
            19: begin r = (b >> a[4:0]) | (b << (32 - int'(a[4:0]))); c = b[31]; w = 1; zn_mode = 1; end
            20: begin r = (b >> q) | (b << (32 - int'(q)));         c = b[31]; w = 1; zn_mode = 1; end
            21, 22: begin
                if (sa < 0) begin
                    r = (-sa >= 32) ? 32'd0 : (b << (-sa));
                    c = b[31];
                end else begin
                    if (op == 21) r = (sa >= 32) ? 32'd0 : (b >> sa);
                    else          r = (sa >= 32) ? {32{b[31]}} : 32'(bs >>> sa);
                    c = b[0];
                end
                w = 1; zn_mode = 1;
            end
            23: begin r = (q == 32) ? 32'd0 : (b >> q);             c = b[0]; w = 1; zn_mode = 1; end
            24: begin r = (q == 32) ? {32{b[31]}} : 32'(bs >>> q);  c = b[0]; w = 1; zn_mode = 1; end
            25, 26, 27: begin
                lim = (op == 25) ? 64'd255 : (op == 26) ? 64'd65535 : 64'd16777215;
                if (bs < 0)                  r = 32'd0;
                else if (longint'(bs) > lim) r = lim[31:0];
                else                         r = b;
                w = 1; zn_mode = 1;
            end
            default: ;
        endcase
        if (zn_mode == 1) begin
            z = (r == 0);
            n = r[31];
        end
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
        end
    endtask

    task automatic do_op(input int op, input logic [31:0] a, input logic [31:0] b,
                         input logic [4:0] im);
        logic [31:0] er;
        logic ew, ez, en, ec;
        @(negedge clk);
        op_valid = 1'b1;
        op_sel   = op[4:0];
        src_a    = a;
        src_b    = b;
        imm      = im;
        ref_op(op, a, b, im, mz, mn, mc, er, ew, ez, en, ec);
        #1;
        check(wr_en === ew, tag_of(op), $sformatf("op %0d wr_en", op), {31'd0, wr_en}, {31'd0, ew});
        if (ew)
            check(result === er, tag_of(op),
                  $sformatf("op %0d a %h b %h imm %0d result", op, a, b, im), result, er);
        @(posedge clk);
        #1;
        check({flag_z, flag_n, flag_c} === {ez, en, ec}, tag_of(op),
              $sformatf("op %0d a %h b %h imm %0d flags ZNC", op, a, b, im),
              {29'd0, flag_z, flag_n, flag_c}, {29'd0, ez, en, ec});
        mz = ez; mn = en; mc = ec;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R1 watchdog got timeout exp completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic exp_t, tflag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: reset state
        check({flag_z, flag_n, flag_c} === 3'b000, "R1", "reset flags", {29'd0, flag_z, flag_n, flag_c}, 32'd0);
        check(wr_en === 1'b0, "R1", "reset wr_en", {31'd0, wr_en}, 32'd0);

        // R1: an operation without op_valid is ignored
        @(negedge clk);
        op_valid = 1'b0; op_sel = 5'd0; src_a = 32'h8000_0000; src_b = 32'h8000_0000;
        #1;
        check(wr_en === 1'b0, "R1", "idle wr_en", {31'd0, wr_en}, 32'd0);
        @(posedge clk);
        #1;
        check({flag_z, flag_n, flag_c} === 3'b000, "R1", "idle flags held", {29'd0, flag_z, flag_n, flag_c}, 32'd0);

        // Sweep every operation code over the operand and immediate sets
        for (int op = 0; op < 32; op++)
            for (int ai = 0; ai < 16; ai++)
                for (int bi = 0; bi < 12; bi++)
                    for (int ii = 0; ii < 6; ii++)
                        do_op(op, val_a(ai), val_b(bi), val_imm(ii));

        // R14: every flag state against every condition code
        for (int fs = 0; fs < 8; fs++) begin
            logic wz, wn, wc;
            wz = fs[2]; wn = fs[1]; wc = fs[0];
            do_op(22, 32'd0, {wn, 30'd0, wc}, 5'd0);
            do_op(18, 32'd0, wz ? 32'd0 : 32'd2, 5'd1);
            @(negedge clk);
            op_valid = 1'b0;
            for (int cc = 0; cc < 32; cc++) begin
                cond_code = cc[4:0];
                #1;
                tflag = cc[4] ? mn : mc;
                exp_t = !((cc[0] && mz) || (cc[1] && !mz) || (cc[2] && tflag) || (cc[3] && !tflag));
                check(branch_taken === exp_t, "R14",
                      $sformatf("code %0d flags ZNC %b%b%b branch", cc, mz, mn, mc),
                      {31'd0, branch_taken}, {31'd0, exp_t});
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule